// File: doc/BRIEF.md
# Control Endpoint Setup Capture

This block sits inside a USB device controller, behind the packet decoder, and stores the eight-byte setup packets that arrive on a set of control endpoints. Each endpoint has its own 64-bit setup buffer. When a full setup packet has been stored, the endpoint's setup-received status bit is set and an interrupt can be raised. Software reads the buffer through a small register port.

Software must be able to copy a buffer out without a new setup packet corrupting it halfway. Two policies are offered. In lockout mode, a buffer whose status bit is still set rejects further setup packets for that endpoint. With lockout turned off, every packet overwrites the buffer. A tripwire bit then tells software that its copy may be stale: software sets the bit before copying, hardware clears it whenever a setup byte is written into any buffer, and a cleared bit after the copy means the copy must be repeated.

The block also tracks endpoint priming. A prime bit is set by software and is resolved by an acknowledge from the transfer engine, which makes the endpoint ready. A setup packet arriving on an endpoint cancels that endpoint's prime and ready state, and a one-cycle pulse reports the prime as failed. The byte stream uses valid/ready. `pkt_ready` is low while in reset and high from the first clock after reset onward, so the block never applies back-pressure. A byte transfers on any cycle where both `pkt_valid` and `pkt_ready` are high.

Top module: `ctl_setup_capture`

## Requirements
- R1: Reset clears the status, prime and ready bits, the tripwire, the lockout-disable bit, the interrupt enable and every buffer byte. `pkt_ready` is 0 during reset and 1 from the first clock edge after reset onward.
- R2: A transfer with `pkt_sop` high starts a packet on endpoint `pkt_ep`. It and the next seven transfers are stored as bytes 0 to 7. Byte k goes to bits 8k+7:8k of the endpoint's 64-bit buffer. Register address 4+2e reads bits 31:0 of endpoint e's buffer and address 5+2e reads bits 63:32.
- R3: After the eighth byte is stored, the endpoint's bit in the status register (address 1) is 1. Writing 1 to a status bit clears it. If a clear and a completion for the same bit fall in the same cycle, the bit stays set.
- R4: With lockout on (control register address 0, bit 0 = 0), a packet that starts on an endpoint whose status bit is set is dropped whole, and its buffer keeps its contents.
- R5: With lockout off (control bit 0 = 1), every packet is stored, even when the endpoint's status bit is set.
- R6: Control bit 1 is the tripwire. A register write sets or clears it. Any setup byte stored into any buffer clears it, and this clear wins over a write that sets the bit in the same cycle.
- R7: `irq` is high exactly when control bit 2 (interrupt enable) is 1 and at least one status bit is 1.
- R8: Writing 1s to the prime register (address 2) sets prime bits. A `prime_ack` bit arriving while its prime bit is set clears that prime bit and sets the endpoint's ready bit (address 3, cleared by writing 1). `prime_done` then pulses for one cycle. A `prime_ack` bit arriving with no prime pending is ignored.
- R9: A completed setup packet clears the endpoint's prime and ready bits. If the prime bit was set, `prime_fail` pulses for one cycle right after.
- R10: A new start-of-packet abandons an unfinished packet, which never sets a status bit. Transfers outside a packet are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Setup byte valid |
| pkt_ready | output | 1 | Byte accepted when high together with valid |
| pkt_sop | input | 1 | First byte of a setup packet |
| pkt_ep | input | EPW | Endpoint number, sampled with the first byte |
| pkt_data | input | 8 | Setup byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| prime_ack | input | NUM_EP | Per-endpoint prime accept from the transfer engine |
| irq | output | 1 | Setup-received interrupt |
| prime_done | output | NUM_EP | One-cycle pulse: prime completed |
| prime_fail | output | NUM_EP | One-cycle pulse: prime failed |

## Verification
The hardest situations to reach are the collisions between software and the packet stream. One is a tripwire set landing in the same cycle as a stored byte. Another is a status clear landing on the cycle of a packet's eighth byte. A third is a prime that is still pending when a setup packet on the same endpoint completes. The bench drives the register port and the byte stream through one per-cycle stimulus task, so it can place a register write on exactly the cycle of a chosen byte. A behavioural model checks the outputs and the register read data after every clock.

// File: rtl/setup_cap_pkg.sv
package setup_cap_pkg;
  localparam int SETUP_BYTES = 8;
  localparam int IDXW        = $clog2(SETUP_BYTES);

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_STAT  = 1;
  localparam int ADDR_PRIME = 2;
  localparam int ADDR_READY = 3;
  localparam int ADDR_BUF0  = 4;

  typedef struct packed {
    logic            en;
    logic [IDXW-1:0] idx;
    logic [7:0]      data;
  } byte_wr_t;
endpackage

// File: rtl/setup_rx.sv
module setup_rx
  import setup_cap_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EPW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              sop,
  input  logic [EPW-1:0]    ep_in,
  input  logic [7:0]        data_in,
  input  logic [NUM_EP-1:0] lock_mask,
  output byte_wr_t          bw,
  output logic [EPW-1:0]    bw_ep,
  output logic              commit
);
  logic            active_q;
  logic [IDXW-1:0] cnt_q;
  logic [EPW-1:0]  ep_q;

  always_comb begin
    bw     = '0;
    bw_ep  = ep_q;
    commit = 1'b0;
    if (beat && sop) begin
      bw_ep = ep_in;
      if (!lock_mask[ep_in]) begin
        bw.en   = 1'b1;
        bw.idx  = '0;
        bw.data = data_in;
      end
    end else if (beat && active_q) begin
      bw.en   = 1'b1;
      bw.idx  = cnt_q;
      bw.data = data_in;
      commit  = (cnt_q == IDXW'(SETUP_BYTES - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      ep_q     <= '0;
    end else if (beat && sop) begin
      active_q <= !lock_mask[ep_in];
      cnt_q    <= IDXW'(1);
      ep_q     <= ep_in;
    end else if (beat && active_q) begin
      cnt_q <= cnt_q + IDXW'(1);
      if (commit) active_q <= 1'b0;
    end
  end

  // R4
  lockout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sop && lock_mask[ep_in]) |=> !active_q);
endmodule

// File: rtl/setup_bufs.sv
module setup_bufs
  import setup_cap_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EPW    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  byte_wr_t                      bw,
  input  logic [EPW-1:0]                bw_ep,
  output logic [NUM_EP*SETUP_BYTES*8-1:0] buf_flat
);
  logic [7:0] mem [NUM_EP][SETUP_BYTES];

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    for (genvar b = 0; b < SETUP_BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[e][b] <= '0;
        else if (bw.en && bw_ep == EPW'(e) && bw.idx == IDXW'(b))
          mem[e][b] <= bw.data;
      end
      assign buf_flat[(e*SETUP_BYTES+b)*8 +: 8] = mem[e][b];
    end
  end

  // R2
  buf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bw.en |=> mem[$past(bw_ep)][$past(bw.idx)] == $past(bw.data));
endmodule

// File: rtl/setup_ctl_regs.sv
module setup_ctl_regs
  import setup_cap_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EPW    = 2,
  parameter int AW     = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [AW-1:0]                   addr,
  input  logic [31:0]                     wdata,
  output logic [31:0]                     rdata,
  input  logic                            byte_stored,
  input  logic                            commit,
  input  logic [EPW-1:0]                  commit_ep,
  input  logic [NUM_EP-1:0]               prime_ack,
  input  logic [NUM_EP*SETUP_BYTES*8-1:0] buf_flat,
  output logic [NUM_EP-1:0]               lock_mask,
  output logic                            irq,
  output logic [NUM_EP-1:0]               prime_done,
  output logic [NUM_EP-1:0]               prime_fail
);
  localparam int WORDS = NUM_EP * 2;

  logic              lockdis_q, trip_q, irqen_q;
  logic              lockdis_n, trip_n, irqen_n;
  logic [NUM_EP-1:0] stat_q, prime_q, ready_q, pprev_q;
  logic [NUM_EP-1:0] stat_n, prime_n, ready_n, ack_hit, wbits;
  logic [AW-1:0]     widx;
  logic              unused_wdata;

  assign wbits        = wdata[NUM_EP-1:0];
  assign unused_wdata = ^wdata;
  assign ack_hit      = prime_ack & prime_q;

  always_comb begin
    lockdis_n = lockdis_q;
    trip_n    = trip_q;
    irqen_n   = irqen_q;
    stat_n    = stat_q;
    prime_n   = prime_q;
    ready_n   = ready_q;
    if (wr_en) begin
      if (addr == AW'(ADDR_CTRL)) begin
        lockdis_n = wdata[0];
        trip_n    = wdata[1];
        irqen_n   = wdata[2];
      end else if (addr == AW'(ADDR_STAT)) begin
        stat_n = stat_q & ~wbits;
      end else if (addr == AW'(ADDR_PRIME)) begin
        prime_n = prime_q | wbits;
      end else if (addr == AW'(ADDR_READY)) begin
        ready_n = ready_q & ~wbits;
      end
    end
    prime_n = prime_n & ~ack_hit;
    ready_n = ready_n | ack_hit;
    if (commit) begin
      stat_n[commit_ep]  = 1'b1;
      prime_n[commit_ep] = 1'b0;
      ready_n[commit_ep] = 1'b0;
    end
    if (byte_stored) trip_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockdis_q <= 1'b0;
      trip_q    <= 1'b0;
      irqen_q   <= 1'b0;
      stat_q    <= '0;
      prime_q   <= '0;
      ready_q   <= '0;
      pprev_q   <= '0;
    end else begin
      lockdis_q <= lockdis_n;
      trip_q    <= trip_n;
      irqen_q   <= irqen_n;
      stat_q    <= stat_n;
      prime_q   <= prime_n;
      ready_q   <= ready_n;
      pprev_q   <= prime_q;
    end
  end

  assign lock_mask  = lockdis_q ? '0 : stat_q;
  assign irq        = irqen_q & (|stat_q);
  assign prime_done = pprev_q & ~prime_q & ready_q;
  assign prime_fail = pprev_q & ~prime_q & ~ready_q;

  assign widx = addr - AW'(ADDR_BUF0);
  always_comb begin
    rdata = '0;
    if (addr == AW'(ADDR_CTRL))
      rdata[2:0] = {irqen_q, trip_q, lockdis_q};
    else if (addr == AW'(ADDR_STAT))
      rdata[NUM_EP-1:0] = stat_q;
    else if (addr == AW'(ADDR_PRIME))
      rdata[NUM_EP-1:0] = prime_q;
    else if (addr == AW'(ADDR_READY))
      rdata[NUM_EP-1:0] = ready_q;
    else if (addr < AW'(ADDR_BUF0 + WORDS))
      rdata = buf_flat[int'(widx)*32 +: 32];
  end

  // R6
  trip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stored |=> !trip_q);
  // R3
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> stat_q[$past(commit_ep)]);
  // R9
  prime_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !prime_q[$past(commit_ep)] && !ready_q[$past(commit_ep)]);
  // R8
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ready_q & ~$past(ready_q)) != '0) |-> ($past(prime_ack & prime_q) != '0));
endmodule

// File: rtl/ctl_setup_capture.sv
module ctl_setup_capture
  import setup_cap_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int AW    = $clog2(ADDR_BUF0 + 2*NUM_EP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic              pkt_sop,
  input  logic [EPW-1:0]    pkt_ep,
  input  logic [7:0]        pkt_data,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_EP-1:0] prime_ack,
  output logic              irq,
  output logic [NUM_EP-1:0] prime_done,
  output logic [NUM_EP-1:0] prime_fail
);
  logic                            rdy_q;
  byte_wr_t                        bw;
  logic [EPW-1:0]                  bw_ep;
  logic                            commit;
  logic [NUM_EP-1:0]               lock_mask;
  logic [NUM_EP*SETUP_BYTES*8-1:0] buf_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign pkt_ready = rdy_q;

  setup_rx #(.NUM_EP(NUM_EP), .EPW(EPW)) u_rx (
    .clk(clk), .rst_n(rst_n), .beat(pkt_valid && rdy_q), .sop(pkt_sop),
    .ep_in(pkt_ep), .data_in(pkt_data), .lock_mask(lock_mask),
    .bw(bw), .bw_ep(bw_ep), .commit(commit)
  );

  setup_bufs #(.NUM_EP(NUM_EP), .EPW(EPW)) u_bufs (
    .clk(clk), .rst_n(rst_n), .bw(bw), .bw_ep(bw_ep), .buf_flat(buf_flat)
  );

  setup_ctl_regs #(.NUM_EP(NUM_EP), .EPW(EPW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .byte_stored(bw.en),
    .commit(commit), .commit_ep(bw_ep), .prime_ack(prime_ack),
    .buf_flat(buf_flat), .lock_mask(lock_mask), .irq(irq),
    .prime_done(prime_done), .prime_fail(prime_fail)
  );
endmodule

// File: tb/ctl_setup_capture_bench.sv
module ctl_setup_capture_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 0, pkt_sop = 0;
  logic [1:0]  pkt_ep = 0;
  logic [7:0]  pkt_data = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [N-1:0] prime_ack = 0;
  logic        pkt_ready, irq;
  logic [31:0] reg_rdata;
  logic [N-1:0] prime_done, prime_fail;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ctl_setup_capture #(.NUM_EP(N)) u_ctl_setup_capture (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_sop(pkt_sop), .pkt_ep(pkt_ep), .pkt_data(pkt_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .prime_ack(prime_ack), .irq(irq),
    .prime_done(prime_done), .prime_fail(prime_fail)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [N-1:0] m_stat, m_prime, m_ready, m_pprev;
  bit         m_trip, m_ld, m_ie, m_rdy, m_act;
  int         m_cnt, m_ep;
  bit [7:0]   m_buf [N][8];

  function automatic bit [31:0] m_read(int a);
    bit [31:0] r = 0;
    if (a == 0) r = {29'd0, m_ie, m_trip, m_ld};
    else if (a == 1) r = 32'(m_stat);
    else if (a == 2) r = 32'(m_prime);
    else if (a == 3) r = 32'(m_ready);
    else if (a < 4 + 2*N) begin
      for (int k = 0; k < 4; k++)
        r[8*k +: 8] = m_buf[(a-4)/2][((a-4)%2)*4 + k];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    bit [N-1:0] old_prime, hit;
    bit stored, done_pkt;
    int cep;
    if (!rst_n) begin
      m_stat = 0; m_prime = 0; m_ready = 0; m_pprev = 0;
      m_trip = 0; m_ld = 0; m_ie = 0; m_rdy = 0; m_act = 0; m_cnt = 0; m_ep = 0;
      for (int e = 0; e < N; e++) for (int b = 0; b < 8; b++) m_buf[e][b] = 0;
    end else begin
      old_prime = m_prime; stored = 0; done_pkt = 0; cep = 0;
      if (pkt_valid && m_rdy && pkt_sop) begin
        if (m_ld || !m_stat[pkt_ep]) begin
          m_buf[pkt_ep][0] = pkt_data; stored = 1; m_act = 1; m_cnt = 1; m_ep = pkt_ep;
        end else m_act = 0;
      end else if (pkt_valid && m_rdy && m_act) begin
        m_buf[m_ep][m_cnt] = pkt_data; stored = 1;
        if (m_cnt == 7) begin done_pkt = 1; cep = m_ep; m_act = 0; end
        m_cnt++;
      end
      if (reg_wr) begin
        case (int'(reg_addr))
          0: begin m_ld = reg_wdata[0]; m_trip = reg_wdata[1]; m_ie = reg_wdata[2]; end
          1: m_stat &= ~reg_wdata[N-1:0];
          2: m_prime |= reg_wdata[N-1:0];
          3: m_ready &= ~reg_wdata[N-1:0];
          default: ;
        endcase
      end
      hit = prime_ack & old_prime;
      m_prime &= ~hit;
      m_ready |= hit;
      if (done_pkt) begin m_stat[cep] = 1; m_prime[cep] = 0; m_ready[cep] = 0; end
      if (stored) m_trip = 0;
      m_pprev = old_prime;
      m_rdy = 1;
    end
    #5;
    chk("R1 pkt_ready", 32'(pkt_ready), 32'(m_rdy));
    chk("R7 irq", 32'(irq), 32'(m_ie && (m_stat != 0)));
    chk("R8 prime_done", 32'(prime_done), 32'(m_pprev & ~m_prime & m_ready));
    chk("R9 prime_fail", 32'(prime_fail), 32'(m_pprev & ~m_prime & ~m_ready));
    chk(reg_addr == 0 ? "R6 ctrl read" : reg_addr == 1 ? "R3 stat read" :
        reg_addr < 4 ? "R8 prime/ready read" : "R2 buffer read",
        reg_rdata, m_read(int'(reg_addr)));
  end

  // ---------------- stimulus ----------------
  task automatic step(bit v, bit s, int e, int d, bit w, int a, int wd, int ack);
    @(negedge clk);
    pkt_valid = v; pkt_sop = s; pkt_ep = 2'(e); pkt_data = 8'(d);
    reg_wr = w; reg_addr = 4'(a); reg_wdata = 32'(wd); prime_ack = N'(ack);
  endtask

  task automatic wr(int a, int d);
    step(0, 0, 0, 0, 1, a, d, 0);
  endtask

  task automatic send(int e, int base);
    for (int k = 0; k < 8; k++) step(1, k == 0, e, base + k, 0, 0, 0, 0);
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    step(0, 0, 0, 0, 0, a, 0, 0);
    #2;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(0, 32'h0, "R1 ctrl after reset");
    rd(1, 32'h0, "R1 stat after reset");
    rd(4, 32'h0, "R1 buffer after reset");
    chk("R1 pkt_ready", 32'(pkt_ready), 32'h1);

    wr(0, 4);
    send(1, 8'h11);
    rd(6, 32'h14131211, "R2 ep1 low word");
    rd(7, 32'h18171615, "R2 ep1 high word");
    rd(1, 32'h2, "R3 stat after packet");
    chk("R7 irq set", 32'(irq), 32'h1);

    send(1, 8'h21);
    rd(6, 32'h14131211, "R4 locked buffer kept");
    wr(1, 2);
    rd(1, 32'h0, "R3 W1C stat");
    chk("R7 irq cleared", 32'(irq), 32'h0);
    send(1, 8'h31);
    rd(6, 32'h34333231, "R4 accepted after release");

    wr(0, 5);
    send(1, 8'h41);
    rd(6, 32'h44434241, "R5 overwrite with lockout off");

    wr(0, 7);
    rd(0, 32'h7, "R6 tripwire set by write");
    send(2, 8'h51);
    rd(0, 32'h5, "R6 tripwire cleared by byte");
    step(1, 1, 2, 8'h61, 1, 0, 7, 0);
    for (int k = 1; k < 8; k++) step(1, 0, 2, 8'h61 + k, 0, 0, 0, 0);
    rd(0, 32'h5, "R6 clear beats same-cycle set");

    wr(2, 1);
    rd(2, 32'h1, "R8 prime set");
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 3, 0, 0);
    #2;
    chk("R8 prime_done pulse", 32'(prime_done), 32'h1);
    rd(3, 32'h1, "R8 ready after ack");
    step(0, 0, 0, 0, 0, 0, 0, 8);
    rd(3, 32'h1, "R8 stray ack ignored");

    wr(2, 4);
    send(2, 8'h71);
    step(0, 0, 0, 0, 0, 2, 0, 0);
    #2;
    chk("R9 prime_fail pulse", 32'(prime_fail), 32'h4);
    rd(2, 32'h0, "R9 prime cleared by setup");
    send(0, 8'h81);
    rd(3, 32'h0, "R9 ready cleared by setup");

    wr(1, 15);
    step(1, 1, 3, 8'hA1, 0, 0, 0, 0);
    step(1, 0, 3, 8'hA2, 0, 0, 0, 0);
    send(3, 8'hB1);
    rd(10, 32'hB4B3B2B1, "R10 restart on new sop");
    rd(1, 32'h8, "R10 only restarted packet completes");
    for (int k = 0; k < 3; k++) step(1, 0, 3, 8'hEE, 0, 0, 0, 0);
    rd(10, 32'hB4B3B2B1, "R10 stray bytes ignored");
    step(1, 1, 0, 8'hC1, 0, 0, 0, 0);
    step(1, 0, 0, 8'hC2, 0, 0, 0, 0);
    rd(1, 32'h8, "R10 short packet no status");

    for (int k = 0; k < 7; k++) step(1, k == 0, 3, 8'hD1 + k, 0, 0, 0, 0);
    step(1, 0, 3, 8'hD8, 1, 1, 8, 0);
    rd(1, 32'h8, "R3 set wins over same-cycle clear");

    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule